// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block decides when a capture system should trigger. It looks at a parallel sample bus, taking one sample per clock, and checks each sample against ten programmable pattern recognizers and an edge term. It then moves through a programmed table of up to twelve levels. Each level names a primary condition and the level it leads to, plus a secondary condition and the level it branches to. A per-level down-counting timer can also serve as a condition. When a transition targets the trigger code, the block emits a one-cycle trigger pulse. It also raises a level output whose rising edge can arm another part of the instrument.

Arming comes from three sources: a run command, a group-run command, or a rising edge on an asynchronous external arm pin, which is synchronized first. Arming restarts the sequence at level 0. A stop command returns the block to idle. All configuration is written through a simple address/data write port.

Top module: `trig_seq`

## Requirements
- R1: Pattern recognizer k (0..9) holds a value at address 0x00+k and a care mask at address 0x10+k, using the low 16 bits of the data. It matches when ((sample ^ value) & care) == 0, so bits whose care bit is 0 always match. Condition select code k picks recognizer k.
- R2: The edge term uses a rise mask at address 0x20 and a fall mask at address 0x21. It is true when any bit selected by the rise mask goes from 0 to 1 between the previous sample and the current one, or when any bit selected by the fall mask goes from 1 to 0. Condition select code 10 picks it.
- R3: Level L (0..11) is configured at address 0x40+L. Bits [3:0] hold the primary select and bits [7:4] the primary target. Bits [11:8] hold the secondary select and bits [15:12] the secondary target. Select codes 12..15 are never true. When the primary condition is true, the sequencer moves to the primary target on the next clock.
- R4: When only the secondary condition is true, the sequencer branches to the secondary target. When both conditions are true in the same cycle, the primary one wins.
- R5: Each level has a 32-bit timer load at address 0x60+L. The timer is loaded on entry to a level, including the level 0 entry at arming. It counts down once per running cycle and stops at zero. Select code 11 is true while the timer is zero, so a load of N makes the condition true N cycles after entry.
- R6: A run or group-run command makes `armed` high and `cur_level` 0 on the next clock. This also clears `trig_out`.
- R7: The external arm pin passes through a two-flop synchronizer. Only its rising edge arms the block, three clocks after the pin rises. Holding the pin high does not arm the block again.
- R8: While the block is not armed, no pattern, edge or timer condition has any effect. A stop command returns the block to idle and clears `trig_out`, and stop takes priority over any arm source in the same cycle.
- R9: A target of 15 fires the trigger. `trig_pulse` is high for exactly one cycle and `trig_out` rises with it. The block then stays triggered, with `armed` low and `trig_out` high, until it is armed again or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_in | input | 16 | Sample bus, one sample per clock |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration address |
| wr_data | input | 32 | Configuration data |
| run_cmd | input | 1 | Run command pulse |
| group_run_cmd | input | 1 | Group-run command pulse |
| stop_cmd | input | 1 | Stop command pulse |
| ext_arm | input | 1 | Asynchronous external arm pin |
| armed | output | 1 | Sequencer is running through levels |
| cur_level | output | 4 | Current sequence level |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_out | output | 1 | External trigger output, rises on trigger |

## Verification
The assertions watch, on every cycle, that the trigger pulse lasts only one cycle and coincides with a fresh rise of `trig_out`. They also check that `trig_out` holds until an arm or stop, that any arm lands at level 0, that stop forces idle, that an idle block never fires, and that an arm from the external pin follows that pin two clocks earlier. The bench scenarios are needed to show the functional content. These scenarios cover recognizer matching under random values and care masks, multi-level advancing, branching and primary priority, the exact timer expiry cycle, rise and fall edge terms, and the three-clock latency and single-shot nature of the external arm.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
    localparam int DATA_W    = 16;
    localparam int NUM_PAT   = 10;
    localparam int NUM_LVL   = 12;
    localparam int TMR_W     = 32;
    localparam int LVL_W     = 4;
    localparam int SEL_W     = 4;
    localparam int ADDR_W    = 8;
    localparam int REG_W     = 32;
    localparam int NUM_TERMS = NUM_PAT + 2;
    localparam int SEL_EDGE  = NUM_PAT;
    localparam int SEL_TIMER = NUM_PAT + 1;

    localparam logic [LVL_W-1:0]  TGT_FIRE  = '1;
    localparam logic [ADDR_W-1:0] A_PVAL    = 8'h00;
    localparam logic [ADDR_W-1:0] A_PCARE   = 8'h10;
    localparam logic [ADDR_W-1:0] A_ERISE   = 8'h20;
    localparam logic [ADDR_W-1:0] A_EFALL   = 8'h21;
    localparam logic [ADDR_W-1:0] A_LCFG    = 8'h40;
    localparam logic [ADDR_W-1:0] A_LTMR    = 8'h60;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRED = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [LVL_W-1:0] sec_tgt;
        logic [SEL_W-1:0] sec_sel;
        logic [LVL_W-1:0] pri_tgt;
        logic [SEL_W-1:0] pri_sel;
    } lvl_cfg_t;

    localparam lvl_cfg_t LVL_CFG_RST = '{sec_tgt: '0, sec_sel: '1,
                                         pri_tgt: '0, pri_sel: '1};

    function automatic logic pick_term(input logic [NUM_TERMS-1:0] terms,
                                       input logic [SEL_W-1:0] sel);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_TERMS; i++) begin
            if (sel == SEL_W'(i)) r = terms[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/trig_pat_bank.sv
module trig_pat_bank
    import trig_seq_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NP = NUM_PAT,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  samp,
    output logic [NP-1:0] hit
);
    for (genvar k = 0; k < NP; k++) begin : g_rec
        logic [W-1:0] val_q;
        logic [W-1:0] care_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q  <= '0;
                care_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == AW'(A_PVAL + k))  val_q  <= wr_data;
                if (wr_addr == AW'(A_PCARE + k)) care_q <= wr_data;
            end
        end

        assign hit[k] = ~|((samp ^ val_q) & care_q);
    end
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import trig_seq_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  samp,
    output logic          edge_hit
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            prev_q <= samp;
            if (wr_en && wr_addr == A_ERISE) rise_q <= wr_data;
            if (wr_en && wr_addr == A_EFALL) fall_q <= wr_data;
        end
    end

    assign edge_hit = |((~prev_q & samp & rise_q) | (prev_q & ~samp & fall_q));
endmodule

// File: rtl/trig_arm_sync.sv
module trig_arm_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/trig_seq_core.sv
module trig_seq_core
    import trig_seq_pkg::*;
#(
    parameter int NP = NUM_PAT,
    parameter int NL = NUM_LVL,
    parameter int TW = TMR_W,
    parameter int AW = ADDR_W,
    parameter int RW = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [RW-1:0]    wr_data,
    input  logic [NP-1:0]    pat_hit,
    input  logic             edge_hit,
    input  logic             arm,
    input  logic             stop,
    output logic             armed,
    output logic [LVL_W-1:0] level,
    output logic             fire_pulse,
    output logic             fire_level
);
    localparam int CFG_W = $bits(lvl_cfg_t);

    lvl_cfg_t        cfg_q  [NL];
    logic [TW-1:0]   load_q [NL];
    seq_state_e      state_q;
    logic [LVL_W-1:0] lvl_q;
    logic [TW-1:0]   tmr_q;
    logic            pulse_q;
    logic            fired_q;

    for (genvar l = 0; l < NL; l++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[l]  <= LVL_CFG_RST;
                load_q[l] <= '0;
            end else if (wr_en) begin
                if (wr_addr == AW'(A_LCFG + l)) cfg_q[l]  <= lvl_cfg_t'(wr_data[CFG_W-1:0]);
                if (wr_addr == AW'(A_LTMR + l)) load_q[l] <= wr_data[TW-1:0];
            end
        end
    end

    logic [NUM_TERMS-1:0] terms;
    lvl_cfg_t             cur_cfg;
    logic                 pri_ok, sec_ok, go;
    logic [LVL_W-1:0]     tgt, tgt_lvl;

    always_comb begin
        terms            = '0;
        terms[NP-1:0]    = pat_hit;
        terms[SEL_EDGE]  = edge_hit;
        terms[SEL_TIMER] = (tmr_q == '0);
        cur_cfg = cfg_q[lvl_q];
        pri_ok  = pick_term(terms, cur_cfg.pri_sel);
        sec_ok  = pick_term(terms, cur_cfg.sec_sel);
        go      = (state_q == ST_RUN) && (pri_ok || sec_ok);
        tgt     = pri_ok ? cur_cfg.pri_tgt : cur_cfg.sec_tgt;
        tgt_lvl = (int'(tgt) < NL) ? tgt : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            tmr_q   <= '0;
            pulse_q <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (stop) begin
                state_q <= ST_IDLE;
                fired_q <= 1'b0;
            end else if (arm) begin
                state_q <= ST_RUN;
                lvl_q   <= '0;
                tmr_q   <= load_q[0];
                fired_q <= 1'b0;
            end else if (go) begin
                if (tgt == TGT_FIRE) begin
                    state_q <= ST_FIRED;
                    pulse_q <= 1'b1;
                    fired_q <= 1'b1;
                end else begin
                    lvl_q <= tgt_lvl;
                    tmr_q <= load_q[tgt_lvl];
                end
            end else if (state_q == ST_RUN && tmr_q != '0) begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
    end

    assign armed      = (state_q == ST_RUN);
    assign level      = lvl_q;
    assign fire_pulse = pulse_q;
    assign fire_level = fired_q;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  samp_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               run_cmd,
    input  logic               group_run_cmd,
    input  logic               stop_cmd,
    input  logic               ext_arm,
    output logic               armed,
    output logic [LVL_W-1:0]   cur_level,
    output logic               trig_pulse,
    output logic               trig_out
);
    logic [NUM_PAT-1:0] pat_hit;
    logic               edge_hit;
    logic               ext_rise;
    logic               arm_evt;

    trig_pat_bank u_pat (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data[DATA_W-1:0]), .samp(samp_in), .hit(pat_hit)
    );

    trig_edge_det u_edge (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data[DATA_W-1:0]), .samp(samp_in), .edge_hit(edge_hit)
    );

    trig_arm_sync u_sync (
        .clk(clk), .rst(rst), .pin(ext_arm), .rise(ext_rise)
    );

    assign arm_evt = run_cmd | group_run_cmd | ext_rise;

    trig_seq_core u_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pat_hit(pat_hit), .edge_hit(edge_hit), .arm(arm_evt), .stop(stop_cmd),
        .armed(armed), .level(cur_level), .fire_pulse(trig_pulse), .fire_level(trig_out)
    );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
    import trig_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run_cmd,
    input logic             group_run_cmd,
    input logic             stop_cmd,
    input logic             ext_arm,
    input logic             arm_evt,
    input logic             armed,
    input logic [LVL_W-1:0] cur_level,
    input logic             trig_pulse,
    input logic             trig_out
);
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    p_pulse_rise_r9: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> (trig_out && !$past(trig_out)));

    p_trig_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (trig_out && !arm_evt && !stop_cmd) |=> trig_out);

    p_arm_level0_r6: assert property (@(posedge clk) disable iff (rst)
        (arm_evt && !stop_cmd) |=> (armed && cur_level == '0 && !trig_out));

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> (!armed && !trig_out));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!armed && !arm_evt) |=> !trig_pulse);

    p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> (int'(cur_level) < NUM_LVL));

    p_ext_source_r7: assert property (@(posedge clk) disable iff (rst)
        (arm_evt && !run_cmd && !group_run_cmd) |-> $past(ext_arm, 2));
endmodule

bind trig_seq trig_seq_chk u_chk (
    .clk(clk), .rst(rst), .run_cmd(run_cmd), .group_run_cmd(group_run_cmd),
    .stop_cmd(stop_cmd), .ext_arm(ext_arm), .arm_evt(arm_evt), .armed(armed),
    .cur_level(cur_level), .trig_pulse(trig_pulse), .trig_out(trig_out)
);

// File: tb/trig_seq_tb_top.sv
module trig_seq_tb_top;
    import trig_seq_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [DATA_W-1:0]  samp_in = '0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [REG_W-1:0]   wr_data = '0;
    logic               run_cmd = 1'b0;
    logic               group_run_cmd = 1'b0;
    logic               stop_cmd = 1'b0;
    logic               ext_arm = 1'b0;
    logic               armed;
    logic [LVL_W-1:0]   cur_level;
    logic               trig_pulse;
    logic               trig_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    trig_seq dut_i (
        .clk(clk), .rst(rst), .samp_in(samp_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run_cmd(run_cmd), .group_run_cmd(group_run_cmd),
        .stop_cmd(stop_cmd), .ext_arm(ext_arm), .armed(armed), .cur_level(cur_level),
        .trig_pulse(trig_pulse), .trig_out(trig_out)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic run();
        run_cmd = 1'b1; step(); run_cmd = 1'b0;
    endtask

    task automatic stop();
        stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    endtask

    function automatic logic [15:0] lcfg(input int ps, input int pt, input int ss, input int st);
        return 16'((st << 12) | (ss << 8) | (pt << 4) | ps);
    endfunction

    function automatic bit exp_match(input logic [15:0] s, input logic [15:0] v, input logic [15:0] c);
        return ((s ^ v) & c) == 16'h0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R9 reset trig_out", 32'(trig_out), 0);
        chk("R6 reset armed", 32'(armed), 0);
        chk("R9 reset pulse", 32'(trig_pulse), 0);

        // patterns: 0 -> 0x00AA/0x00FF, 1 -> 0x5500/0xFF00
        wr(8'h00, 32'h00AA); wr(8'h10, 32'h00FF);
        wr(8'h01, 32'h5500); wr(8'h11, 32'hFF00);
        wr(8'h40, 32'(lcfg(0, 1, 15, 0)));
        wr(8'h41, 32'(lcfg(1, 15, 15, 0)));

        // R8: ignored while idle
        samp_in = 16'h55AA;
        repeat (4) step();
        chk("R8 idle ignores match trig_out", 32'(trig_out), 0);
        chk("R8 idle ignores match armed", 32'(armed), 0);

        // R3 multi-level advance
        samp_in = 16'h0000;
        run();
        chk("R6 run arms", 32'(armed), 1);
        chk("R6 run level0", 32'(cur_level), 0);
        samp_in = 16'h5500; step();
        chk("R3 level1 cond at level0 no move", 32'(cur_level), 0);
        samp_in = 16'h00AA; step();
        chk("R3 advance to level1", 32'(cur_level), 1);
        step();
        chk("R3 stay level1", 32'(cur_level), 1);
        chk("R3 no trigger yet", 32'(trig_out), 0);
        samp_in = 16'h55AA; step();
        chk("R9 pulse on fire", 32'(trig_pulse), 1);
        chk("R9 trig_out rises", 32'(trig_out), 1);
        step();
        chk("R9 pulse one cycle", 32'(trig_pulse), 0);
        chk("R9 trig_out held", 32'(trig_out), 1);
        chk("R9 not armed after fire", 32'(armed), 0);
        repeat (3) step();
        chk("R9 stays triggered", 32'(trig_out), 1);

        // R8 stop clears
        stop();
        chk("R8 stop clears trig_out", 32'(trig_out), 0);

        // R4 branch on secondary
        wr(8'h40, 32'(lcfg(0, 15, 1, 2)));
        wr(8'h42, 32'(lcfg(15, 0, 15, 0)));
        samp_in = 16'h0000;
        run();
        samp_in = 16'h5500; step();
        chk("R4 secondary branch to level2", 32'(cur_level), 2);
        chk("R4 branch no trigger", 32'(trig_out), 0);
        samp_in = 16'h0000;
        run();
        chk("R6 re-arm level0", 32'(cur_level), 0);
        samp_in = 16'h55AA; step();
        chk("R4 primary wins", 32'(trig_out), 1);
        chk("R4 primary wins level", 32'(cur_level), 0);

        // R8 stop beats arm
        run_cmd = 1'b1; stop_cmd = 1'b1; step(); run_cmd = 1'b0; stop_cmd = 1'b0;
        chk("R8 stop over run", 32'(armed), 0);

        // R5 timer
        wr(8'h40, 32'(lcfg(11, 15, 15, 0)));
        wr(8'h60, 32'd5);
        samp_in = 16'h0000;
        run();
        repeat (5) step();
        chk("R5 timer not yet expired", 32'(trig_out), 0);
        step();
        chk("R5 timer expiry fires", 32'(trig_out), 1);
        // timer reload on entry: level0 -> level1 with load 3, level1 timer -> fire
        wr(8'h40, 32'(lcfg(0, 1, 15, 0)));
        wr(8'h41, 32'(lcfg(11, 15, 15, 0)));
        wr(8'h61, 32'd3);
        run();
        samp_in = 16'h00AA; step();
        samp_in = 16'h0000;
        chk("R5 entered level1", 32'(cur_level), 1);
        repeat (3) step();
        chk("R5 level1 timer pending", 32'(trig_out), 0);
        step();
        chk("R5 level1 timer fires", 32'(trig_out), 1);

        // R2 rising edge
        stop();
        wr(8'h20, 32'h0008); wr(8'h21, 32'h0000);
        wr(8'h40, 32'(lcfg(10, 15, 15, 0)));
        samp_in = 16'h0000; step();
        run();
        chk("R2 no edge no trigger", 32'(trig_out), 0);
        samp_in = 16'h0008; step();
        chk("R2 rise fires", 32'(trig_out), 1);
        // R2 falling edge
        stop();
        wr(8'h20, 32'h0000); wr(8'h21, 32'h0020);
        samp_in = 16'h0020; step();
        run();
        step();
        chk("R2 steady high no fall", 32'(trig_out), 0);
        samp_in = 16'h0000; step();
        chk("R2 fall fires", 32'(trig_out), 1);

        // R7 external arm
        stop();
        wr(8'h40, 32'(lcfg(0, 15, 15, 0)));
        samp_in = 16'h0000;
        ext_arm = 1'b1;
        step(); step();
        chk("R7 not armed after two clocks", 32'(armed), 0);
        step();
        chk("R7 armed after three clocks", 32'(armed), 1);
        samp_in = 16'h00AA; step();
        chk("R7 fire after ext arm", 32'(trig_out), 1);
        repeat (4) step();
        chk("R7 held pin does not re-arm", 32'(trig_out), 1);
        ext_arm = 1'b0;
        repeat (3) step();

        // R6 group run
        samp_in = 16'h0000;
        group_run_cmd = 1'b1; step(); group_run_cmd = 1'b0;
        chk("R6 group run arms", 32'(armed), 1);
        chk("R6 group run clears trig_out", 32'(trig_out), 0);
        stop();

        // R1 random recognizer checks
        for (int it = 0; it < 150; it++) begin
            int k;
            logic [15:0] v, c, s;
            bit e;
            k = int'($urandom_range(0, NUM_PAT - 1));
            v = 16'($urandom);
            c = 16'($urandom);
            if (it % 7 == 0) c = 16'h0000;
            wr(8'(k), 32'(v));
            wr(8'(8'h10 + k), 32'(c));
            wr(8'h40, 32'(lcfg(k, 15, 15, 0)));
            run();
            s = 16'($urandom);
            if ($urandom_range(0, 1) == 1) s = v ^ (16'($urandom) & ~c);
            e = exp_match(s, v, c);
            samp_in = s; step();
            chk($sformatf("R1 recognizer %0d match", k), 32'(trig_out), 32'(e));
            samp_in = 16'h0000;
            stop();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule